// File: doc/BRIEF.md
# Keypad Matrix Scanner with Sample-Window Debounce

This block scans a 4x4 switch matrix. It pulls one row line low at a time and reads the four column lines back. From these it produces a stable key number between 0 and 15. The row drive advances on a slow scan enable (a few kHz in practice). While a row is driven low, the column pattern seen for that row is captured into a small per-row store. The whole matrix therefore stays visible between visits to any one row. The block combines the row position and the column position into a key number. A second, much slower sample enable (around 10 Hz) feeds that number into a history window. The number is passed on only once every entry in the window agrees.

Downstream logic reads `key_value` and treats the all-ones value as "nothing pressed". Keys 0–9 are digits and keys 10–13 are the four operators: add, subtract, multiply and equals. Keys 14 and 15 carry no meaning for the consumer. `key_valid` marks each fresh press for exactly one clock cycle.

Top module: `keypad_scan_filter`

## Requirements
- R1: A synchronous active-low reset forces `row_drive` to 4'b0111, `key_value` to 5'b11111 and `key_valid` to 0, and empties the sample history and the per-row stores.
- R2: Each cycle with `scan_tick` high moves the single low row bit one place up, following 0111 → 1110 → 1101 → 1011 → 0111. Without `scan_tick` the row drive holds.
- R3: Exactly one bit of `row_drive` is low at any time outside reset.
- R4: Row index r is the position of the low bit in `row_drive` (1110 is r=0). Column index c is the position of the low bit in `col_sense` (1110 is c=0). A single closed switch at (r, c) reports key 4*r + c.
- R5: With no switch closed, or with more than one column low for one row, that row reads as no-key and `key_value` settles to 5'b11111.
- R6: The column pattern of each row is captured only during that row's own scan slot and held until its next slot. A held key therefore reads as pressed at every sample instant, whichever row is driven at that moment.
- R7: A key number reaches `key_value` only after 8 consecutive `sample_tick` samples all hold that same number. Seven equal samples, or alternating samples, leave the output unchanged.
- R8: `key_valid` is high for one cycle, in the same cycle that a key number (not 5'b11111) first appears on `key_value` after a no-key value was accepted.
- R9: While a key stays accepted, no further strobe fires. Changing straight to another key updates `key_value` without a strobe. A new strobe needs the no-key value to be accepted first.
- R10: When switches in several rows are closed, the key in the lowest row index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_tick | input | 1 | One-cycle enable that advances the row scan |
| sample_tick | input | 1 | One-cycle enable that takes a debounce sample |
| col_sense | input | 4 | Column lines, low where a closed switch meets the driven row |
| row_drive | output | 4 | Row lines, one driven low |
| key_value | output | 5 | Accepted key number, 5'b11111 for none |
| key_valid | output | 1 | One-cycle strobe for a new press |

## Verification
A table of matrix states checks the decode. It covers single keys in every row and in the outer columns, two columns closed in one row (which must decode to no-key), and keys in two rows (which shows the lowest-row priority). Each entry is followed by a release, so every press is also checked for exactly one strobe. Directed runs separate seven equal samples from eight, and show that alternating bounce samples never pass. A direct key-to-key change is checked to update the value without a strobe. A test that takes one scan step per sample shows that a key whose row is not being driven at the sample instant is still reported, which only the per-row store makes possible.

// File: rtl/keypad_scan_pkg.sv
// Shared defaults for the keypad scanner: matrix size, debounce window,
// and the derived key-number width (one extra bit carries the no-key code).
package keypad_scan_pkg;
    localparam int KP_ROWS    = 4;
    localparam int KP_COLS    = 4;
    localparam int KP_SAMPLES = 8;

    // Width of a key number plus room for the all-ones no-key value.
    function automatic int kp_key_width(input int rows, input int cols);
        return $clog2(rows * cols) + 1;
    endfunction
endpackage

// File: rtl/keypad_row_scan.sv
// Row scanner: a counter stepped by scan_tick selects which row line is
// driven low. Counter value 1 selects row 0, value 0 selects the last row.
// Assumes ROWS is a power of two and at least 2.
module keypad_row_scan
    import keypad_scan_pkg::*;
#(
    parameter int ROWS = KP_ROWS,
    localparam int CNT_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    output logic [ROWS-1:0]  row_drive,
    output logic [CNT_W-1:0] row_sel
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the scan position once per enable, wrapping at ROWS-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (scan_tick)
            cnt_q <= (cnt_q == CNT_W'(ROWS - 1)) ? '0 : cnt_q + CNT_W'(1);
    end

    // Purpose: map the counter to a row index and a single-low row pattern.
    always_comb begin
        row_sel   = (cnt_q == '0) ? CNT_W'(ROWS - 1) : cnt_q - CNT_W'(1);
        row_drive = ~(ROWS'(1) << row_sel);
    end
endmodule

// File: rtl/keypad_key_lookup.sv
// Per-row column store and key decode. Each row keeps the column pattern
// captured during its own scan slot; the decode picks the lowest row with
// exactly one low column and returns row*COLS + column, else all ones.
// Assumes col_sense is already synchronous to clk.
module keypad_key_lookup
    import keypad_scan_pkg::*;
#(
    parameter int ROWS  = KP_ROWS,
    parameter int COLS  = KP_COLS,
    parameter int KEY_W = kp_key_width(KP_ROWS, KP_COLS),
    localparam int CNT_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic [CNT_W-1:0] row_sel,
    input  logic [COLS-1:0]  col_sense,
    output logic [KEY_W-1:0] frame_key
);
    logic [COLS-1:0] sense_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row_store
        // Purpose: capture this row's columns at the end of its scan slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sense_q[r] <= '1;
            else if (scan_tick && row_sel == CNT_W'(r))
                sense_q[r] <= col_sense;
        end
    end

    // Purpose: turn the stored matrix image into one key number, lowest row first.
    always_comb begin
        frame_key = '1;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if ($countones(~sense_q[r]) == 1) begin
                for (int c = 0; c < COLS; c++) begin
                    if (!sense_q[r][c])
                        frame_key = KEY_W'(r * COLS + c);
                end
            end
        end
    end
endmodule

// File: rtl/keypad_debounce.sv
// Sample-window filter: on each sample_tick the current key number enters a
// SAMPLES-deep history. When every entry agrees, that number is accepted.
// A strobe fires once when a key is accepted after an accepted no-key value.
module keypad_debounce
    import keypad_scan_pkg::*;
#(
    parameter int KEY_W   = kp_key_width(KP_ROWS, KP_COLS),
    parameter int SAMPLES = KP_SAMPLES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic [KEY_W-1:0] frame_key,
    output logic [KEY_W-1:0] key_value,
    output logic             key_valid
);
    localparam logic [KEY_W-1:0] NO_KEY = '1;

    logic [KEY_W-1:0]   hist_q [SAMPLES];
    logic [SAMPLES-1:0] same;
    logic               all_eq;
    logic               armed_q;
    logic               fire;

    // Purpose: shift the newest key number into the history on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SAMPLES; i++) hist_q[i] <= NO_KEY;
        end else if (sample_tick) begin
            hist_q[0] <= frame_key;
            for (int i = 1; i < SAMPLES; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    for (genvar g = 0; g < SAMPLES; g++) begin : g_cmp
        assign same[g] = (hist_q[g] == hist_q[0]);
    end

    assign all_eq = &same;
    assign fire   = all_eq && (hist_q[0] != NO_KEY) && armed_q;

    // Purpose: accept an agreed value, and arm/disarm the press strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_value <= NO_KEY;
            armed_q   <= 1'b1;
            key_valid <= 1'b0;
        end else begin
            key_valid <= fire;
            if (all_eq)
                key_value <= hist_q[0];
            if (all_eq && hist_q[0] == NO_KEY)
                armed_q <= 1'b1;
            else if (fire)
                armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/keypad_scan_filter.sv
// Top of the keypad scanner: row scan, per-row column store with decode,
// and the sample-window debounce. Both enables come from outside dividers.
module keypad_scan_filter
    import keypad_scan_pkg::*;
#(
    parameter int ROWS    = KP_ROWS,
    parameter int COLS    = KP_COLS,
    parameter int SAMPLES = KP_SAMPLES,
    localparam int KEY_W  = kp_key_width(ROWS, COLS),
    localparam int CNT_W  = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic             sample_tick,
    input  logic [COLS-1:0]  col_sense,
    output logic [ROWS-1:0]  row_drive,
    output logic [KEY_W-1:0] key_value,
    output logic             key_valid
);
    logic [CNT_W-1:0] row_sel;
    logic [KEY_W-1:0] frame_key;

    keypad_row_scan #(.ROWS(ROWS)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .row_drive (row_drive),
        .row_sel   (row_sel)
    );

    keypad_key_lookup #(.ROWS(ROWS), .COLS(COLS), .KEY_W(KEY_W)) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .row_sel   (row_sel),
        .col_sense (col_sense),
        .frame_key (frame_key)
    );

    keypad_debounce #(.KEY_W(KEY_W), .SAMPLES(SAMPLES)) u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .frame_key   (frame_key),
        .key_value   (key_value),
        .key_valid   (key_valid)
    );
endmodule

// File: rtl/keypad_scan_filter_chk.sv
// Property checker for keypad_scan_filter, attached through bind.
// Observes only the top-level ports.
module keypad_scan_filter_chk
    import keypad_scan_pkg::*;
#(
    parameter int ROWS  = KP_ROWS,
    parameter int KEY_W = kp_key_width(KP_ROWS, KP_COLS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_tick,
    input logic [ROWS-1:0]  row_drive,
    input logic [KEY_W-1:0] key_value,
    input logic             key_valid
);
    localparam logic [KEY_W-1:0] NO_KEY = '1;
    localparam logic [ROWS-1:0]  ROW_RST = {1'b0, {(ROWS-1){1'b1}}};

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (row_drive == ROW_RST && key_value == NO_KEY && !key_valid));

    p_one_row_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_drive) == 1);

    p_row_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick |=> row_drive == {$past(row_drive[ROWS-2:0]), $past(row_drive[ROWS-1])});

    p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(row_drive));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    p_strobe_has_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> key_value != NO_KEY);

    p_strobe_after_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> $past(key_value) == NO_KEY);
endmodule

bind keypad_scan_filter keypad_scan_filter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .row_drive (row_drive),
    .key_value (key_value),
    .key_valid (key_valid)
);

// File: tb/keypad_scan_filter_test.sv
module keypad_scan_filter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        scan_tick;
    logic        sample_tick;
    logic [15:0] pressed;
    logic [3:0]  col_sense;
    logic [3:0]  row_drive;
    logic [4:0]  key_value;
    logic        key_valid;

    int n_checks = 0;
    int n_bad    = 0;
    int vcount   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    keypad_scan_filter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_tick   (scan_tick),
        .sample_tick (sample_tick),
        .col_sense   (col_sense),
        .row_drive   (row_drive),
        .key_value   (key_value),
        .key_valid   (key_valid)
    );

    // Switch matrix model: key r*4+c pulls column c low while row r is low.
    always_comb begin
        for (int c = 0; c < 4; c++) begin
            col_sense[c] = 1'b1;
            for (int r = 0; r < 4; r++)
                if (pressed[r*4+c] && !row_drive[r]) col_sense[c] = 1'b0;
        end
    end

    // Vector: {pressed mask, expected key}
    localparam logic [20:0] VEC [9] = '{
        {16'h0001, 5'd0},  {16'h0020, 5'd5},  {16'h0400, 5'd10},
        {16'h8000, 5'd15}, {16'h0008, 5'd3},  {16'h1000, 5'd12},
        {16'h0003, 5'h1F}, {16'h0240, 5'd6},  {16'h0000, 5'h1F}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            vcount += int'(key_valid);
        end
    endtask

    task automatic pulse_scan();
        scan_tick = 1'b1;
        @(negedge clk);
        vcount += int'(key_valid);
        scan_tick = 1'b0;
    endtask

    task automatic sample_once(input int nscan);
        repeat (nscan) begin
            pulse_scan();
            idle(1);
        end
        sample_tick = 1'b1;
        @(negedge clk);
        vcount += int'(key_valid);
        sample_tick = 1'b0;
        idle(2);
    endtask

    task automatic samples(input int n, input int nscan);
        repeat (n) sample_once(nscan);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] rot_exp [4];
        rot_exp = '{4'b1110, 4'b1101, 4'b1011, 4'b0111};
        rst_n = 1'b0; scan_tick = 1'b0; sample_tick = 1'b0; pressed = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(row_drive == 4'b0111, "R1 row", row_drive, 7);
        chk(key_value == 5'h1F, "R1 key", key_value, 31);
        chk(key_valid == 1'b0, "R1 strobe", key_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: rotation order and single low row
        for (int k = 0; k < 4; k++) begin
            pulse_scan();
            chk(row_drive == rot_exp[k], "R2 rotate", row_drive, rot_exp[k]);
            chk($countones(~row_drive) == 1, "R3 one row low", row_drive, rot_exp[k]);
        end
        idle(3);
        chk(row_drive == 4'b0111, "R2 hold", row_drive, 7);

        // Table walk: R4 decode, R5 no-key, R10 priority, R8 strobe per press
        for (int i = 0; i < 9; i++) begin
            automatic logic [15:0] m = VEC[i][20:5];
            automatic logic [4:0]  e = VEC[i][4:0];
            automatic string t = (e == 5'h1F) ? "R5" : (($countones(m) > 1) ? "R10" : "R4");
            pressed = m;
            vcount = 0;
            samples(8, 4);
            chk(key_value == e, t, key_value, e);
            chk(vcount == ((e != 5'h1F) ? 1 : 0), "R8 strobe count", vcount, (e != 5'h1F) ? 1 : 0);
            pressed = '0;
            samples(8, 4);
            chk(key_value == 5'h1F, "R5 release", key_value, 31);
        end

        // R7: seven equal samples are not enough, eight are
        pressed = 16'h0080;
        samples(7, 4);
        chk(key_value == 5'h1F, "R7 seven", key_value, 31);
        samples(1, 4);
        chk(key_value == 5'd7, "R7 eight", key_value, 7);
        pressed = '0;
        samples(8, 4);

        // R7: bouncing input never passes
        vcount = 0;
        for (int k = 0; k < 6; k++) begin
            pressed = (k % 2 == 0) ? 16'h0010 : 16'h0000;
            sample_once(4);
        end
        chk(key_value == 5'h1F, "R7 bounce value", key_value, 31);
        chk(vcount == 0, "R7 bounce strobe", vcount, 0);
        pressed = '0;
        samples(8, 4);

        // R9: no repeat while held, no strobe on key-to-key change, re-arm after release
        pressed = 16'h0004;
        vcount = 0;
        samples(8, 4);
        chk(key_value == 5'd2 && vcount == 1, "R8 first press", vcount, 1);
        vcount = 0;
        samples(8, 4);
        chk(key_value == 5'd2, "R9 held value", key_value, 2);
        chk(vcount == 0, "R9 held strobe", vcount, 0);
        pressed = 16'h0080;
        samples(8, 4);
        chk(key_value == 5'd7, "R9 change value", key_value, 7);
        chk(vcount == 0, "R9 change strobe", vcount, 0);
        pressed = '0;
        samples(8, 4);
        pressed = 16'h0080;
        vcount = 0;
        samples(8, 4);
        chk(vcount == 1, "R9 rearm strobe", vcount, 1);
        pressed = '0;
        samples(8, 4);

        // R6: one scan step per sample; held key must read at every sample
        pressed = 16'h2000;
        vcount = 0;
        samples(12, 1);
        chk(key_value == 5'd13, "R6 latched value", key_value, 13);
        chk(vcount == 1, "R6 latched strobe", vcount, 1);
        pressed = '0;
        samples(8, 4);
        chk(key_value == 5'h1F, "R6 release", key_value, 31);

        // R1: reset while a key is accepted
        pressed = 16'h0002;
        samples(8, 4);
        chk(key_value == 5'd1, "R4 before reset", key_value, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(key_value == 5'h1F, "R1 mid reset key", key_value, 31);
        chk(row_drive == 4'b0111, "R1 mid reset row", row_drive, 7);
        chk(key_valid == 1'b0, "R1 mid reset strobe", key_valid, 0);
        rst_n = 1'b1;
        pressed = '0;
        idle(2);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule